// File: doc/BRIEF.md
# Indirect register window for a network controller

This block is the host-facing register front end of a network controller. The host sees a small window of 16-bit ports. One port holds a register pointer. Two other ports act as data windows: one reaches the control/status bank and one reaches the bus-configuration bank, both at the index held in the pointer. A fourth port resets the controller when it is read and needs no write.

The block holds the run state of the controller, which is one of stopped, initializing, initialized or running. Write-one command bits in control register 0 move the controller between these states. Initialization is stood in for by an internal stub that signals completion a fixed number of clocks after it is started. The block also holds the two-word identification value, the init-block address registers and the descriptor-style register. It drives a one-cycle transmit-demand pulse towards the transmit engine.

Top module: `nic_regport`

## Requirements
- R1: After hardware reset: control register 0 reads 0x0004 (only the stop bit, bit 2), the pointer reads 0, bus register 20 reads 0, `initAddr` is 0, and `macRun` and `txDemand` are low.
- R2: The pointer port at byte offset 0x12 is readable and writable and keeps the low PTR_W bits of a write. With PTR_W=7, writing 88 reads back 88 and writing 0x00D8 reads back 0x0058.
- R3: The control data port at offset 0x10 reaches the register selected by the pointer. Index 1 holds the low half and index 2 the high half of the init-block address, and `initAddr` equals {index 2, index 1}.
- R4: Index 88 of the control bank reads {PART_CODE[3:0], 12'h003} and index 89 reads {4'h0, PART_CODE[15:4]}. Writes to either have no effect.
- R5: Through the bus data port at offset 0x16, bus register 20 is read/write. `wideDesc` is high exactly when its low byte equals 2.
- R6: A control index other than 0, 1, 2, 88 or 89, and a bus index other than 20, reads as 0 and ignores writes.
- R7: Writing control register 0 with bit 0 set while stopped starts initialization, and the register then reads 0x0001. Exactly INIT_CYCLES clocks after the write edge, bit 8 (init done) becomes set and the register reads 0x0101. A bit-0 write in any other state is ignored.
- R8: A bit-1 write while initialized enters running: bit 1 reads 1, bits 0 and 2 read 0, and `macRun` goes high. A bit-1 write in any other state is ignored.
- R9: A bit-2 write in any state returns the controller to stopped (0x0004), clears bit 8 and aborts an ongoing initialization. In the same write, bit 2 takes priority over bits 0, 1 and 3.
- R10: Writing 1 to bit 8 clears the init-done flag. Writing 0 to bit 8 leaves it unchanged.
- R11: A bit-3 write while running raises `txDemand` for exactly one clock, in the cycle after the write edge. The same write in any other state is ignored, and bit 3 always reads 0.
- R12: A read at offset 0x14 returns 0 and, from the next clock, puts the controller in the stopped state with init done cleared. The pointer, the init-block address and bus register 20 keep their values. A write at 0x14 has no effect.
- R13: `ioRdata` is 0 whenever no read is presented, and also for reads at offsets other than 0x10, 0x12, 0x14 and 0x16. Writes at such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| ioSel | input | 1 | An access to the window is presented this cycle |
| ioWrite | input | 1 | 1 for a write, 0 for a read |
| ioAddr | input | ADDR_W | Byte offset inside the window |
| ioWdata | input | 16 | Write data |
| ioRdata | output | 16 | Read data, valid in the same cycle as the read |
| initAddr | output | 32 | Init-block address assembled from control indices 2 and 1 |
| wideDesc | output | 1 | 32-bit descriptor style selected |
| macRun | output | 1 | Controller is in the running state |
| txDemand | output | 1 | One-cycle transmit-demand pulse |

## Verification
The bench builds the block with INIT_CYCLES=4. This keeps the initialization window short enough that a stop can land inside it, which exercises the abort path, and it lets init done be watched arriving on its exact clock. PART_CODE is set to 0x2625 instead of the default, so the split of the part code across indices 88 and 89 is checked against a non-default value. PTR_W stays 7, so indices 88 and 89 can be reached and an 8-bit pointer write shows the truncation.

// File: rtl/nic_regport_pkg.sv
package nic_regport_pkg;

  localparam int WORD_W = 16;

  // byte offsets inside the host window
  localparam int OFF_CSR = 'h10;
  localparam int OFF_PTR = 'h12;
  localparam int OFF_RST = 'h14;
  localparam int OFF_BCR = 'h16;

  // register indices reached through the pointer
  localparam int IDX_CTL    = 0;
  localparam int IDX_IADRLO = 1;
  localparam int IDX_IADRHI = 2;
  localparam int IDX_IDLO   = 88;
  localparam int IDX_IDHI   = 89;
  localparam int IDX_STYLE  = 20;

  // command slice handed to the control: {done-clear, demand, stop, start, init}
  localparam int CMD_INIT = 0;
  localparam int CMD_STRT = 1;
  localparam int CMD_STOP = 2;
  localparam int CMD_TDMD = 3;
  localparam int CMD_IDON = 4;

  typedef enum logic [1:0] {
    RUN_STOPPED = 2'd0,
    RUN_INITING = 2'd1,
    RUN_INITED  = 2'd2,
    RUN_ACTIVE  = 2'd3
  } runState_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PTR  = 2'd1,
    RD_CSR  = 2'd2,
    RD_BCR  = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic    ptrWr;
    logic    csrWr;
    logic    bcrWr;
    rdKind_e rdKind;
  } dpStrobe_t;

endpackage

// File: rtl/nic_regport_initstub.sv
module nic_regport_initstub #(
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic abort,
  output logic done
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (abort) begin
      remain <= '0;
    end else if (start) begin
      remain <= CNT_W'(INIT_CYCLES);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign done = (remain == CNT_W'(1));

endmodule

// File: rtl/nic_regport_ctrl.sv
module nic_regport_ctrl
  import nic_regport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int PTR_W  = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ioSel,
  input  logic                ioWrite,
  input  logic [ADDR_W-1:0]   ioAddr,
  input  logic [4:0]          cmdBits,
  input  logic [PTR_W-1:0]    ptr,
  input  logic                initDone,
  output dpStrobe_t           stb,
  output logic [WORD_W-1:0]   csr0,
  output logic                initStart,
  output logic                initAbort,
  output logic                macRun,
  output logic                txDemand
);
  runState_e state;
  logic      idon;

  logic accRd, accWr;
  logic hitCsr, hitPtr, hitRst, hitBcr;
  logic ctlWr, softRst;
  logic initCmd, strtCmd, stopCmd, tdmdCmd, idonClr;

  assign accRd  = ioSel && !ioWrite;
  assign accWr  = ioSel && ioWrite;
  assign hitCsr = (ioAddr == ADDR_W'(OFF_CSR));
  assign hitPtr = (ioAddr == ADDR_W'(OFF_PTR));
  assign hitRst = (ioAddr == ADDR_W'(OFF_RST));
  assign hitBcr = (ioAddr == ADDR_W'(OFF_BCR));

  assign ctlWr   = accWr && hitCsr && (ptr == PTR_W'(IDX_CTL));
  assign softRst = accRd && hitRst;

  assign initCmd = ctlWr && cmdBits[CMD_INIT];
  assign strtCmd = ctlWr && cmdBits[CMD_STRT];
  assign stopCmd = ctlWr && cmdBits[CMD_STOP];
  assign tdmdCmd = ctlWr && cmdBits[CMD_TDMD];
  assign idonClr = ctlWr && cmdBits[CMD_IDON];

  // strobes to the datapath
  always_comb begin
    stb.ptrWr = accWr && hitPtr;
    stb.csrWr = accWr && hitCsr;
    stb.bcrWr = accWr && hitBcr;
    if (!accRd)      stb.rdKind = RD_NONE;
    else if (hitPtr) stb.rdKind = RD_PTR;
    else if (hitCsr) stb.rdKind = RD_CSR;
    else if (hitBcr) stb.rdKind = RD_BCR;
    else             stb.rdKind = RD_NONE;
  end

  assign initStart = initCmd && !stopCmd && (state == RUN_STOPPED);
  assign initAbort = softRst || stopCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= RUN_STOPPED;
      idon     <= 1'b0;
      txDemand <= 1'b0;
    end else begin
      txDemand <= tdmdCmd && !stopCmd && (state == RUN_ACTIVE);
      if (initAbort) begin
        state <= RUN_STOPPED;
        idon  <= 1'b0;
      end else begin
        unique case (state)
          RUN_STOPPED: if (initCmd) state <= RUN_INITING;
          RUN_INITING: if (initDone) state <= RUN_INITED;
          RUN_INITED:  if (strtCmd) state <= RUN_ACTIVE;
          default:     state <= state;
        endcase
        if (initDone && state == RUN_INITING) idon <= 1'b1;
        else if (idonClr)                     idon <= 1'b0;
      end
    end
  end

  always_comb begin
    csr0    = '0;
    csr0[0] = (state == RUN_INITING) || (state == RUN_INITED);
    csr0[1] = (state == RUN_ACTIVE);
    csr0[2] = (state == RUN_STOPPED);
    csr0[8] = idon;
  end

  assign macRun = (state == RUN_ACTIVE);

  // R12
  soft_reset_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (state == RUN_STOPPED) && !idon);

  // R7
  idon_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idon) |-> $past(state) == RUN_INITING);

  // R11
  tx_pulse_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDemand |-> $past(state) == RUN_ACTIVE);

  // R8
  run_after_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(macRun) |-> $past(state) == RUN_INITED);

  // R7
  done_only_initing_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> state == RUN_INITING);

endmodule

// File: rtl/nic_regport_regs.sv
module nic_regport_regs
  import nic_regport_pkg::*;
#(
  parameter int          PTR_W     = 7,
  parameter logic [15:0] PART_CODE = 16'h2621
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [WORD_W-1:0] ioWdata,
  input  logic [WORD_W-1:0] csr0,
  output logic [PTR_W-1:0]  ptr,
  output logic [WORD_W-1:0] ioRdata,
  output logic [31:0]       initAddr,
  output logic              wideDesc
);
  localparam logic [31:0] ID_WORD = {4'h0, PART_CODE, 12'h003};
  localparam logic [WORD_W-1:0] ID_LO = ID_WORD[15:0];
  localparam logic [WORD_W-1:0] ID_HI = ID_WORD[31:16];

  logic [WORD_W-1:0] adrLo, adrHi, style;
  logic [WORD_W-1:0] csrView, bcrView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr   <= '0;
      adrLo <= '0;
      adrHi <= '0;
      style <= '0;
    end else begin
      if (stb.ptrWr) ptr <= ioWdata[PTR_W-1:0];
      if (stb.csrWr && ptr == PTR_W'(IDX_IADRLO)) adrLo <= ioWdata;
      if (stb.csrWr && ptr == PTR_W'(IDX_IADRHI)) adrHi <= ioWdata;
      if (stb.bcrWr && ptr == PTR_W'(IDX_STYLE))  style <= ioWdata;
    end
  end

  always_comb begin
    case (ptr)
      PTR_W'(IDX_CTL):    csrView = csr0;
      PTR_W'(IDX_IADRLO): csrView = adrLo;
      PTR_W'(IDX_IADRHI): csrView = adrHi;
      PTR_W'(IDX_IDLO):   csrView = ID_LO;
      PTR_W'(IDX_IDHI):   csrView = ID_HI;
      default:            csrView = '0;
    endcase
    bcrView = (ptr == PTR_W'(IDX_STYLE)) ? style : '0;
    case (stb.rdKind)
      RD_PTR:  ioRdata = WORD_W'(ptr);
      RD_CSR:  ioRdata = csrView;
      RD_BCR:  ioRdata = bcrView;
      default: ioRdata = '0;
    endcase
  end

  assign initAddr = {adrHi, adrLo};
  assign wideDesc = (style[7:0] == 8'd2);

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ptrWr |=> $stable(ptr));

  // R3
  init_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.csrWr |=> $stable(initAddr));

  // R5
  style_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.bcrWr |=> $stable(wideDesc));

  // R13
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdKind == RD_NONE |-> ioRdata == '0);

endmodule

// File: rtl/nic_regport.sv
module nic_regport
  import nic_regport_pkg::*;
#(
  parameter int          ADDR_W      = 5,
  parameter int          PTR_W       = 7,
  parameter logic [15:0] PART_CODE   = 16'h2621,
  parameter int          INIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioSel,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [15:0]       ioWdata,
  output logic [15:0]       ioRdata,
  output logic [31:0]       initAddr,
  output logic              wideDesc,
  output logic              macRun,
  output logic              txDemand
);
  dpStrobe_t         stb;
  logic [WORD_W-1:0] csr0;
  logic [PTR_W-1:0]  ptr;
  logic              initStart, initAbort, initDone;
  logic [4:0]        cmdBits;

  assign cmdBits = {ioWdata[8], ioWdata[3:0]};

  nic_regport_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioSel(ioSel), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .cmdBits(cmdBits), .ptr(ptr), .initDone(initDone), .stb(stb), .csr0(csr0),
    .initStart(initStart), .initAbort(initAbort), .macRun(macRun),
    .txDemand(txDemand)
  );

  nic_regport_regs #(.PTR_W(PTR_W), .PART_CODE(PART_CODE)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .ioWdata(ioWdata), .csr0(csr0),
    .ptr(ptr), .ioRdata(ioRdata), .initAddr(initAddr), .wideDesc(wideDesc)
  );

  nic_regport_initstub #(.INIT_CYCLES(INIT_CYCLES)) u_stub (
    .clk(clk), .rstN(rstN), .start(initStart), .abort(initAbort),
    .done(initDone)
  );

endmodule

// File: tb/nic_regport_test.sv
module nic_regport_test;
  localparam int          PTRW  = 7;
  localparam logic [15:0] PART  = 16'h2625;
  localparam int          INITN = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioSel = 1'b0;
  logic        ioWrite = 1'b0;
  logic [4:0]  ioAddr = '0;
  logic [15:0] ioWdata = '0;
  logic [15:0] ioRdata;
  logic [31:0] initAddr;
  logic        wideDesc, macRun, txDemand;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  nic_regport #(.ADDR_W(5), .PTR_W(PTRW), .PART_CODE(PART), .INIT_CYCLES(INITN)) uut (
    .clk(clk), .rstN(rstN), .ioSel(ioSel), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .initAddr(initAddr),
    .wideDesc(wideDesc), .macRun(macRun), .txDemand(txDemand)
  );

  always #5 clk = ~clk;

  // behavioural reference: 0 stopped, 1 initializing, 2 initialized, 3 running
  int mState = 0, mIdon = 0, mPtr = 0, mLo = 0, mHi = 0, mBcr = 0, mRemain = 0, mTx = 0;

  function automatic int expRead();
    int v;
    v = 0;
    if (ioSel && !ioWrite) begin
      if (ioAddr == 5'h12) v = mPtr;
      else if (ioAddr == 5'h10) begin
        if (mPtr == 0)
          v = (mIdon << 8) | ((mState == 0) ? 4 : 0) | ((mState == 3) ? 2 : 0)
              | ((mState == 1 || mState == 2) ? 1 : 0);
        else if (mPtr == 1) v = mLo;
        else if (mPtr == 2) v = mHi;
        else if (mPtr == 88) v = ((int'(PART) & 'hF) << 12) | 3;
        else if (mPtr == 89) v = int'(PART) >> 4;
      end else if (ioAddr == 5'h16) begin
        if (mPtr == 20) v = mBcr;
      end
    end
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mIdon = 0; mPtr = 0; mLo = 0; mHi = 0; mBcr = 0; mRemain = 0; mTx = 0;
    end else begin
      int old;
      int d;
      bit doneNow;
      old = mState;
      d = int'(ioWdata);
      doneNow = 0;
      mTx = 0;
      if (ioSel && !ioWrite && ioAddr == 5'h14) begin
        mState = 0; mIdon = 0; mRemain = 0;
      end else if (ioSel && ioWrite && ioAddr == 5'h10 && mPtr == 0 && d[2]) begin
        mState = 0; mIdon = 0; mRemain = 0;
      end else begin
        if (old == 1) begin
          if (mRemain == 1) begin mState = 2; doneNow = 1; mRemain = 0; end
          else mRemain = mRemain - 1;
        end
        if (ioSel && ioWrite) begin
          case (ioAddr)
            5'h12: mPtr = d & ((1 << PTRW) - 1);
            5'h16: if (mPtr == 20) mBcr = d;
            5'h10: begin
              if (mPtr == 1) mLo = d;
              else if (mPtr == 2) mHi = d;
              else if (mPtr == 0) begin
                if (d[0] && old == 0) begin mState = 1; mRemain = INITN; end
                else if (d[1] && old == 2) mState = 3;
                if (d[3] && old == 3) mTx = 1;
                if (d[8] && !doneNow) mIdon = 0;
              end
            end
            default: ;
          endcase
        end
        if (doneNow) mIdon = 1;
      end
    end
  end

  // cycle-by-cycle comparison against the reference
  always begin
    @(negedge clk);
    #3;
    if (!finished) begin
      checks++;
      if (int'(ioRdata) != expRead()) begin
        errors++;
        $display("FAIL model ioRdata (R2 R3 R4 R5 R13) got %h exp %h", ioRdata, expRead());
      end
      if (int'(txDemand) != mTx || int'(macRun) != (mState == 3 ? 1 : 0)) begin
        errors++;
        $display("FAIL model run/demand (R8 R11) got run=%0d tx=%0d exp run=%0d tx=%0d",
                 macRun, txDemand, (mState == 3), mTx);
      end
      if (initAddr != {mHi[15:0], mLo[15:0]} || int'(wideDesc) != (((mBcr & 255) == 2) ? 1 : 0)) begin
        errors++;
        $display("FAIL model addr/style (R3 R5) got %h %0d", initAddr, wideDesc);
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    ioSel = 1; ioWrite = 1; ioAddr = a; ioWdata = d;
    @(negedge clk);
    ioSel = 0; ioWrite = 0; ioAddr = '0; ioWdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, input int exp, input string tag);
    @(negedge clk);
    ioSel = 1; ioWrite = 0; ioAddr = a; ioWdata = '0;
    #2;
    chk(tag, int'(ioRdata), exp);
    @(negedge clk);
    ioSel = 0; ioAddr = '0;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1;
    // R1 reset state
    rd(5'h12, 0, "R1 pointer");
    rd(5'h10, 'h0004, "R1 ctl");
    wr(5'h12, 20);
    rd(5'h16, 0, "R1 bus20");
    chk("R1 run", int'(macRun), 0);
    chk("R1 addr", int'(initAddr), 0);
    // R2 pointer
    wr(5'h12, 88);
    rd(5'h12, 88, "R2 readback");
    wr(5'h12, 16'h00D8);
    rd(5'h12, 'h58, "R2 truncate");
    // R4 identification
    wr(5'h12, 88);
    rd(5'h10, 'h5003, "R4 low");
    wr(5'h12, 89);
    rd(5'h10, 'h0262, "R4 high");
    wr(5'h10, 16'hFFFF);
    rd(5'h10, 'h0262, "R4 write ignored");
    // R3 init-block address
    wr(5'h12, 1); wr(5'h10, 16'h3000);
    wr(5'h12, 2); wr(5'h10, 16'h0012);
    rd(5'h10, 'h0012, "R3 high half");
    chk("R3 initAddr", int'(initAddr), 'h00123000);
    // R5 descriptor style
    wr(5'h12, 20); wr(5'h16, 16'h0102);
    rd(5'h16, 'h0102, "R5 readback");
    chk("R5 wide", int'(wideDesc), 1);
    wr(5'h16, 16'h0003);
    chk("R5 not wide", int'(wideDesc), 0);
    wr(5'h16, 16'h0002);
    // R6 unimplemented indices
    wr(5'h12, 5); wr(5'h10, 16'hBEEF);
    rd(5'h10, 0, "R6 csr5");
    wr(5'h12, 20); wr(5'h10, 16'h1234);
    rd(5'h10, 0, "R6 csr20");
    rd(5'h16, 'h0002, "R6 bus20 untouched");
    wr(5'h12, 21); wr(5'h16, 16'h7777);
    rd(5'h16, 0, "R6 bus21");
    chk("R6 addr untouched", int'(initAddr), 'h00123000);
    // R8/R11 ignored while stopped
    wr(5'h12, 0);
    wr(5'h10, 16'h0002);
    rd(5'h10, 'h0004, "R8 start ignored when stopped");
    wr(5'h10, 16'h0008);
    #2; chk("R11 demand ignored when stopped", int'(txDemand), 0);
    // R7 initialization
    wr(5'h10, 16'h0001);
    rd(5'h10, 'h0001, "R7 initializing");
    waitCyc(INITN + 2);
    rd(5'h10, 'h0101, "R7 done");
    wr(5'h10, 16'h0001);
    rd(5'h10, 'h0101, "R7 init ignored when initialized");
    // R10 done-flag clearing
    wr(5'h10, 16'h0000);
    rd(5'h10, 'h0101, "R10 zero keeps");
    wr(5'h10, 16'h0100);
    rd(5'h10, 'h0001, "R10 one clears");
    // R8 start
    wr(5'h10, 16'h0002);
    rd(5'h10, 'h0002, "R8 running");
    chk("R8 macRun", int'(macRun), 1);
    // R11 transmit demand
    wr(5'h10, 16'h0008);
    #2; chk("R11 pulse", int'(txDemand), 1);
    @(negedge clk); #2; chk("R11 one cycle", int'(txDemand), 0);
    rd(5'h10, 'h0002, "R11 reads zero");
    // R9 stop priority
    wr(5'h10, 16'h000E);
    #2; chk("R9 no demand with stop", int'(txDemand), 0);
    rd(5'h10, 'h0004, "R9 stopped");
    chk("R9 macRun", int'(macRun), 0);
    // R9 abort initialization
    wr(5'h10, 16'h0001);
    wr(5'h10, 16'h0004);
    waitCyc(INITN + 4);
    rd(5'h10, 'h0004, "R9 abort");
    // R12 reset port
    wr(5'h10, 16'h0001);
    waitCyc(INITN + 2);
    wr(5'h10, 16'h0002);
    rd(5'h10, 'h0102, "R12 running before");
    wr(5'h14, 16'hFFFF);
    rd(5'h10, 'h0102, "R12 write ignored");
    rd(5'h14, 0, "R12 read data");
    rd(5'h10, 'h0004, "R12 stopped");
    rd(5'h12, 0, "R12 pointer kept");
    chk("R12 addr kept", int'(initAddr), 'h00123000);
    chk("R12 style kept", int'(wideDesc), 1);
    // R13 other offsets
    rd(5'h00, 0, "R13 offset 0");
    rd(5'h18, 0, "R13 offset 18");
    rd(5'h11, 0, "R13 odd offset");
    wr(5'h18, 16'h0055);
    rd(5'h12, 0, "R13 write ignored");
    waitCyc(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule